// File: doc/BRIEF.md
# Branch Target Buffer

This block is a direct-indexed branch target buffer that the fetch stage consults on every cycle. A lookup port takes the current fetch PC. It returns a hit flag, a taken prediction and the PC to fetch next. The next PC is the recorded target when an entry with a matching tag predicts taken. In every other case it is the sequential address PC + 4. Each entry holds a valid bit, the full upper address bits of the branch as a tag, the last taken target and a two-bit direction counter.

When a branch resolves, the pipeline presents its PC, its real target and its outcome on the update port. In that same cycle the block raises a mispredict flag for the recovery logic. The flag is set if the buffer would have sent fetch down the wrong path. At the next clock edge the block trains the counter of a matching entry and refreshes its target. A taken branch that missed claims its indexed slot, replacing whatever was there. A not-taken branch that missed leaves the table alone.

The direction counter is a four-state machine:
- Strong not-taken: encoding 00.
- Weak not-taken: encoding 01.
- Weak taken: encoding 10.
- Strong taken: encoding 11.

A taken outcome moves the counter one state toward strong taken. A not-taken outcome moves it one state toward strong not-taken. The two end states saturate. The counter predicts taken in the two states whose upper bit is 1. A newly allocated entry starts in weak taken.

Top module: `btb_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, with lk_hit=0, lk_taken=0 and lk_next_pc = lk_pc + 4.
- R2: A lookup that misses gives lk_hit=0, lk_taken=0 and lk_next_pc = lk_pc + 4. Entries at other indices do not affect it.
- R3: An update with up_taken=1 that misses writes its indexed entry with the tag, up_target and the weak-taken state (10). A lookup of that PC from the next cycle hits, predicts taken and gives lk_next_pc = up_target.
- R4: An update with up_taken=0 that misses changes no entry. A later lookup of that PC still misses.
- R5: On a hit, the update moves the direction counter one state in the direction of the outcome: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. The counter saturates at 00 and at 11. The prediction is taken exactly when the counter's upper bit is 1.
- R6: A hit whose counter predicts not-taken gives lk_hit=1, lk_taken=0 and lk_next_pc = lk_pc + 4.
- R7: The index is lk_pc[IDX_W+1:2] and the tag is lk_pc[PC_W-1:IDX_W+2]. A PC that shares an index with a stored branch but differs in its tag misses.
- R8: A taken update that hits replaces the stored target with up_target.
- R9: During an update cycle, up_mispredict=1 when the buffer's direction prediction differs from up_taken. It is also 1 when the buffer predicted taken, the branch was taken and the stored target differs from up_target. In every other update cycle it is 0.
- R10: An update takes effect at the clock edge that ends its cycle. A lookup of the same PC in the same cycle sees the earlier contents.
- R11: A taken update that aliases onto an occupied index replaces the old entry, and the old branch then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all valid bits |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_hit | output | 1 | Valid entry with matching tag found |
| lk_taken | output | 1 | Hit and counter predicts taken |
| lk_next_pc | output | PC_W | Predicted next fetch PC |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_target | input | PC_W | Actual target of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_mispredict | output | 1 | Buffer would have steered fetch wrongly for this branch |

## Verification
The assertions assume several things about the inputs:
- PCs on both ports are word aligned.
- up_pc, up_target and up_taken are known whenever up_valid is high.
- Reset is held low for at least one clock edge before the first use.

The stimulus keeps to these assumptions. Every address is a multiple of four, and the update fields are driven to defined values even in cycles where up_valid is low. Reset is applied at start-up and again mid-run, each time for several cycles, with all inputs idle.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Two-bit direction counter; the upper bit is the prediction.
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

endpackage

// File: rtl/btb_ctr_fsm.sv
module btb_ctr_fsm
    import btb_pkg::*;
(
    input  ctr_e cur,
    input  logic outcome,
    output ctr_e nxt,
    output logic predict
);

    // Transition process.
    always_comb begin
        unique case (cur)
            CTR_SNT: nxt = outcome ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = outcome ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = outcome ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = outcome ? CTR_ST  : CTR_WT;
            default: nxt = CTR_WT;
        endcase
    end

    // Output process.
    always_comb begin
        unique case (cur)
            CTR_SNT, CTR_WNT: predict = 1'b0;
            CTR_WT,  CTR_ST:  predict = 1'b1;
            default:          predict = 1'b0;
        endcase
    end

endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    localparam int TAG_W  = PC_W - IDX_W - 2,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    // read port A (fetch lookup)
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_vld,
    output logic [TAG_W-1:0] ra_tag,
    output logic [PC_W-1:0]  ra_tgt,
    output ctr_e             ra_ctr,
    // read port B (resolution)
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_vld,
    output logic [TAG_W-1:0] rb_tag,
    output logic [PC_W-1:0]  rb_tgt,
    output ctr_e             rb_ctr,
    // write port
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_tgt_en,
    input  logic [PC_W-1:0]  wr_tgt,
    input  ctr_e             wr_ctr
);

    logic [ENTRIES-1:0] vld_vec;
    logic [TAG_W-1:0]   tag_arr [ENTRIES];
    logic [PC_W-1:0]    tgt_arr [ENTRIES];
    ctr_e               ctr_arr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic [PC_W-1:0]  d_q;
        ctr_e             c_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                c_q <= CTR_WNT;
            end else if (sel) begin
                v_q <= 1'b1;
                c_q <= wr_ctr;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                t_q <= wr_tag;
                if (wr_tgt_en) d_q <= wr_tgt;
            end
        end

        assign vld_vec[g] = v_q;
        assign tag_arr[g] = t_q;
        assign tgt_arr[g] = d_q;
        assign ctr_arr[g] = c_q;
    end

    assign ra_vld = vld_vec[ra_idx];
    assign ra_tag = tag_arr[ra_idx];
    assign ra_tgt = tgt_arr[ra_idx];
    assign ra_ctr = ctr_arr[ra_idx];

    assign rb_vld = vld_vec[rb_idx];
    assign rb_tag = tag_arr[rb_idx];
    assign rb_tgt = tgt_arr[rb_idx];
    assign rb_ctr = ctr_arr[rb_idx];

    AST_IDLE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vld_vec)); // R4

    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_vec[$past(wr_idx)]); // R3

endmodule

// File: rtl/btb_probe.sv
module btb_probe
    import btb_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] ent_tag,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag,
    output logic             hit
);

    assign idx = pc[IDX_W+1:2];
    assign tag = pc[PC_W-1:IDX_W+2];
    assign hit = ent_vld && (ent_tag == tag);

endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic [PC_W-1:0] up_target,
    input  logic            up_taken,
    output logic            up_mispredict
);

    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             a_vld, b_vld;
    logic [TAG_W-1:0] a_tag, b_tag;
    logic [PC_W-1:0]  a_tgt, b_tgt;
    ctr_e             a_ctr, b_ctr;
    logic             up_hit;
    logic             a_pred, b_pred;
    ctr_e             a_nxt_unused, b_nxt;
    logic             wr_en;
    ctr_e             wr_ctr;

    btb_entry_array #(.PC_W(PC_W), .IDX_W(IDX_W)) i_arr (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(lk_idx), .ra_vld(a_vld), .ra_tag(a_tag), .ra_tgt(a_tgt), .ra_ctr(a_ctr),
        .rb_idx(up_idx), .rb_vld(b_vld), .rb_tag(b_tag), .rb_tgt(b_tgt), .rb_ctr(b_ctr),
        .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag),
        .wr_tgt_en(up_taken), .wr_tgt(up_target), .wr_ctr(wr_ctr)
    );

    btb_probe #(.PC_W(PC_W), .IDX_W(IDX_W)) i_lk_probe (
        .pc(lk_pc), .ent_vld(a_vld), .ent_tag(a_tag),
        .idx(lk_idx), .tag(lk_tag), .hit(lk_hit)
    );

    btb_probe #(.PC_W(PC_W), .IDX_W(IDX_W)) i_up_probe (
        .pc(up_pc), .ent_vld(b_vld), .ent_tag(b_tag),
        .idx(up_idx), .tag(up_tag), .hit(up_hit)
    );

    btb_ctr_fsm i_lk_ctr (.cur(a_ctr), .outcome(1'b0), .nxt(a_nxt_unused), .predict(a_pred));
    btb_ctr_fsm i_up_ctr (.cur(b_ctr), .outcome(up_taken), .nxt(b_nxt), .predict(b_pred));

    // Lookup outputs.
    assign lk_taken   = lk_hit && a_pred;
    assign lk_next_pc = lk_taken ? a_tgt : lk_pc + PC_W'(4);

    // Resolution: train on hit, allocate on a taken miss.
    logic up_pred_taken, up_tgt_diff;
    assign up_pred_taken = up_hit && b_pred;
    assign up_tgt_diff   = up_hit && (b_tgt != up_target);
    assign up_mispredict = up_valid &&
                           ((up_pred_taken != up_taken) || (up_pred_taken && up_taken && up_tgt_diff));
    assign wr_en  = up_valid && (up_hit || up_taken);
    assign wr_ctr = up_hit ? b_nxt : CTR_WT;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit); // R1

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_next_pc == lk_pc + PC_W'(4))); // R2

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken |-> lk_hit); // R6

    AST_TAKEN_MISS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && !up_hit) |-> up_mispredict); // R9

    AST_ALLOC_HITS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && (lk_pc == up_pc)) |=> ($stable(lk_pc) |-> lk_hit)); // R10

endmodule

// File: tb/test_btb_top.sv
module test_btb_top;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_hit, lk_taken;
    logic [PC_W-1:0] lk_next_pc;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic [PC_W-1:0] up_target = '0;
    logic            up_taken = 1'b0;
    logic            up_mispredict;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    btb_top #(.PC_W(PC_W), .IDX_W(4)) i_btb_top (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
        .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target), .up_taken(up_taken),
        .up_mispredict(up_mispredict)
    );

    typedef struct packed {
        logic        is_upd;
        logic [31:0] pc;
        logic [31:0] tgt;
        logic        tk;
        logic        e_hit;
        logic        e_tk;
        logic [31:0] e_next;
        logic        e_misp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    // A=0x1008 and B=0x2008 share index 2; C=0x1010 is index 4.
    localparam vec_t TBL [NV] = '{
        '{1'b0, 32'h1008, 32'h0,    1'b0, 1'b0, 1'b0, 32'h100C, 1'b0, 4'd1},  // R1 empty
        '{1'b1, 32'h1008, 32'h4000, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 4'd4},  // R4 NT miss
        '{1'b0, 32'h1008, 32'h0,    1'b0, 1'b0, 1'b0, 32'h100C, 1'b0, 4'd4},  // R4 no alloc
        '{1'b1, 32'h1008, 32'h4000, 1'b1, 1'b0, 1'b0, 32'h0,    1'b1, 4'd9},  // R9 taken miss
        '{1'b0, 32'h1008, 32'h0,    1'b0, 1'b1, 1'b1, 32'h4000, 1'b0, 4'd3},  // R3 alloc WT
        '{1'b1, 32'h1008, 32'h4000, 1'b1, 1'b0, 1'b0, 32'h0,    1'b0, 4'd9},  // R9 correct -> ST
        '{1'b1, 32'h1008, 32'h4000, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 4'd9},  // R9 ST->WT
        '{1'b1, 32'h1008, 32'h4000, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 4'd5},  // R5 WT->WNT
        '{1'b0, 32'h1008, 32'h0,    1'b0, 1'b1, 1'b0, 32'h100C, 1'b0, 4'd6},  // R6 hit NT
        '{1'b1, 32'h1008, 32'h4000, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 4'd5},  // R5 WNT->SNT
        '{1'b1, 32'h1008, 32'h4000, 1'b0, 1'b0, 1'b0, 32'h0,    1'b0, 4'd5},  // R5 SNT sat
        '{1'b1, 32'h1008, 32'h4000, 1'b1, 1'b0, 1'b0, 32'h0,    1'b1, 4'd5},  // R5 SNT->WNT
        '{1'b0, 32'h1008, 32'h0,    1'b0, 1'b1, 1'b0, 32'h100C, 1'b0, 4'd5},  // R5 still NT
        '{1'b1, 32'h1008, 32'h5000, 1'b1, 1'b0, 1'b0, 32'h0,    1'b1, 4'd8},  // R8 WNT->WT
        '{1'b0, 32'h1008, 32'h0,    1'b0, 1'b1, 1'b1, 32'h5000, 1'b0, 4'd8},  // R8 new target
        '{1'b1, 32'h1008, 32'h6000, 1'b1, 1'b0, 1'b0, 32'h0,    1'b1, 4'd9},  // R9 target diff
        '{1'b0, 32'h2008, 32'h0,    1'b0, 1'b0, 1'b0, 32'h200C, 1'b0, 4'd7},  // R7 alias miss
        '{1'b1, 32'h2008, 32'h7000, 1'b1, 1'b0, 1'b0, 32'h0,    1'b1, 4'd11}, // R11 overwrite
        '{1'b0, 32'h1008, 32'h0,    1'b0, 1'b0, 1'b0, 32'h100C, 1'b0, 4'd11}, // R11 old misses
        '{1'b0, 32'h2008, 32'h0,    1'b0, 1'b1, 1'b1, 32'h7000, 1'b0, 4'd11}, // R11 new hits
        '{1'b0, 32'h1010, 32'h0,    1'b0, 1'b0, 1'b0, 32'h1014, 1'b0, 4'd2}   // R2 other index
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic look(input string tag, input logic [31:0] pc,
                        input logic eh, input logic et, input logic [31:0] en);
        check(tag, "lookup", {lk_hit, lk_taken, lk_next_pc[29:0]}, {eh, et, en[29:0]});
        if (pc !== lk_pc) $display("note: pc mismatch");
    endtask

    task automatic upd(input logic [31:0] pc, input logic [31:0] tg, input logic tk);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_target = tg; up_taken = tk;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, sampled before any update.
        lk_pc = 32'h3000; #1;
        look("R1", lk_pc, 1'b0, 1'b0, 32'h3004);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (TBL[i].is_upd) begin
                up_valid = 1'b1; up_pc = TBL[i].pc; up_target = TBL[i].tgt; up_taken = TBL[i].tk;
                lk_pc = 32'h0;
                #1;
                check($sformatf("R%0d", TBL[i].req), $sformatf("mispredict row %0d", i),
                      {31'b0, up_mispredict}, {31'b0, TBL[i].e_misp});
            end else begin
                up_valid = 1'b0;
                lk_pc = TBL[i].pc;
                #1;
                check($sformatf("R%0d", TBL[i].req), $sformatf("lookup row %0d", i),
                      {lk_hit, lk_taken, lk_next_pc[29:0]},
                      {TBL[i].e_hit, TBL[i].e_tk, TBL[i].e_next[29:0]});
            end
        end
        @(negedge clk);
        up_valid = 1'b0;

        // R10: same-cycle lookup sees old contents, next cycle sees new.
        lk_pc = 32'h1010; up_valid = 1'b1; up_pc = 32'h1010; up_target = 32'h8000; up_taken = 1'b1;
        #1;
        look("R10", lk_pc, 1'b0, 1'b0, 32'h1014);
        @(negedge clk);
        up_valid = 1'b0; #1;
        look("R10", lk_pc, 1'b1, 1'b1, 32'h8000);

        // R5: saturate at strong taken; one not-taken stays predicting taken.
        upd(32'h1010, 32'h8000, 1'b1);
        upd(32'h1010, 32'h8000, 1'b1);
        upd(32'h1010, 32'h8000, 1'b1);
        upd(32'h1010, 32'h8000, 1'b0);
        #1;
        look("R5", lk_pc, 1'b1, 1'b1, 32'h8000);

        // R1: mid-run reset clears all entries.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; #1;
        look("R1", lk_pc, 1'b0, 1'b0, 32'h1014);
        lk_pc = 32'h2008; #1;
        look("R1", lk_pc, 1'b0, 1'b0, 32'h200C);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule